// File: doc/BRIEF.md
# Complex Debug Trigger Unit

This unit sits beside a processor core. It watches the stream of executed instruction addresses and the data-memory access bus, and produces three trigger pulses: one asks the core to halt, one starts trace capture and one stops it. The unit does more than compare a single address. A trigger can depend on an ordered chain of breakpoint hits. It can depend on an instruction hit followed by a matching data access. It can wait for a programmed number of hits, or it can be gated by a data value written to or read from a chosen location.

The unit has four instruction comparators and two data comparators. Each comparator has its own pass counter. A data comparator matches on address, on access direction (optional) and on a data value compared only in the bytes that a byte mask selects. On top of the comparators sit three functions: a primed sequencer of up to four steps, one instruction+data pair (a tuple), and a value qualifier that can enable or disable chosen instruction comparators. A routing register maps each of eight trigger sources to an action. Software programs the unit through a single-cycle register write port.

Top module: `dbg_trig_unit`

## Requirements
- R1: Primed sequence (register 0x20). Bits [2:0], [5:3], [8:6] and [11:9] give the source of steps 0 to 3, where source codes 0-3 are instruction comparators and 4-5 are data comparators. Bits [14:12] give the length, and 0 turns the sequence off. The step counter advances by one when the current step's source fires. A hit of any other source leaves it unchanged. The last step fires the sequence and returns the counter to step 0, and so does any write to 0x20.
- R2: Tuple (register 0x21). Bit 0 enables it, bits [2:1] select the instruction comparator and bit 3 selects the data comparator. A hit of the selected instruction comparator arms the tuple. The first data access in a later cycle decides the outcome: if the selected data comparator fires on that access, the tuple fires; otherwise the tuple is cancelled.
- R3: Pass count. Each comparator holds a pass count P (instruction comparator offset +2, data comparator offset +3, bits [15:0], where 0 acts as 1). A write loads the count into the comparator's counter. The counter decrements on every raw match. The comparator fires on every P-th raw match, and the counter reloads from P when it fires.
- R4: Qualifier. Register 0x22 holds the enable in bit 0 and the data comparator select in bit 1. Register 0x23 holds the reference value. An access that meets the selected comparator's address and direction sets the qualifier state if its data equals the reference value and clears it otherwise. The state is cleared at reset. An instruction comparator whose qualified bit is set can match only while the state is set.
- R5: Routing (register 0x24) gives each source k a 2-bit action in bits [2k+1:2k]. Sources 0-3 are the instruction comparators, 4-5 the data comparators, 6 the sequence and 7 the tuple. Action codes are 0 none, 1 halt, 2 trace on, 3 trace off. The chosen output goes high exactly in the cycle after the bus cycle that fired the source, and for that one cycle only.
- R6: Data comparator j has its registers at 0x10+4j: +0 address, +1 reference value, +2 control. In the control register, bit 0 is enable, bit 1 turns on the direction check, bit 2 gives the required direction (1 = write), and bits [7:4] are a byte mask in which bit n compares data byte n. A raw match needs a valid access whose address is equal, whose direction agrees when the check is on, and whose masked bytes are equal.
- R7: Instruction comparator i has its registers at 4i: +0 address, +1 control (bit 0 enable, bit 1 qualified). A raw match needs a valid executed instruction whose address equals the programmed address.
- R8: After reset all outputs are low, all comparators are disabled, the sequence and tuple are off, and every pass count is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | DW | Register write data |
| ex_valid | input | 1 | An instruction executes this cycle |
| ex_addr | input | AW | Address of the executed instruction |
| mem_valid | input | 1 | A data access happens this cycle |
| mem_addr | input | AW | Data access address |
| mem_write | input | 1 | 1 = store, 0 = load |
| mem_data | input | DW | Store or load data |
| halt_o | output | 1 | Halt request pulse |
| trace_on_o | output | 1 | Trace start pulse |
| trace_off_o | output | 1 | Trace stop pulse |

## Verification
Assertions check on every cycle that the pass counters never hold zero, that they reload after a firing and decrement after a raw match, and that the sequencer stays inside its length and holds still when its current source is idle. They also check that a decided tuple disarms, that the qualifier follows the observed value, and that a halt-routed sequence firing reaches the halt pin one cycle later. Only the bench's scenarios can show the end-to-end orderings: a sequence rejecting out-of-order hits, a tuple cancelled by a mismatching access, every third hit firing, and byte-masked value matches.

// File: rtl/dbg_trig_pkg.sv
// Package: shared action encoding and register map of the debug trigger unit.
// Assumes: action codes fit the 2-bit routing fields.
package dbg_trig_pkg;
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_HALT  = 2'd1,
        ACT_TRON  = 2'd2,
        ACT_TROFF = 2'd3
    } act_e;

    localparam logic [3:0] BLK_IBP  = 4'h0;
    localparam logic [3:0] BLK_DBP  = 4'h1;
    localparam logic [3:0] BLK_MISC = 4'h2;

    localparam logic [3:0] MISC_SEQ   = 4'h0;
    localparam logic [3:0] MISC_TUPLE = 4'h1;
    localparam logic [3:0] MISC_QCTL  = 4'h2;
    localparam logic [3:0] MISC_QVAL  = 4'h3;
    localparam logic [3:0] MISC_ROUTE = 4'h4;
endpackage

// File: rtl/dbg_pass_ctr.sv
// Pass counter: fires on every P-th raw match and reloads after each firing.
// Assumes: a programmed count of 0 behaves as 1; a load wins over a match.
module dbg_pass_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [CW-1:0] ld_val,
    input  logic          raw,
    output logic          fire
);
    logic [CW-1:0] pass_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] pass_eff;

    // Effective count: zero is treated as one.
    assign pass_eff = (pass_q == '0) ? CW'(1) : pass_q;
    assign fire     = raw && (cnt_q <= CW'(1));

    // Counter state: load on write, otherwise count raw matches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_q <= CW'(1);
            cnt_q  <= CW'(1);
        end else if (ld_en) begin
            pass_q <= ld_val;
            cnt_q  <= (ld_val == '0) ? CW'(1) : ld_val;
        end else if (raw) begin
            cnt_q  <= fire ? pass_eff : cnt_q - CW'(1);
        end
    end

    p_cnt_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != '0);
    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !ld_en) |=> cnt_q == $past(pass_eff));
    p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (raw && !fire && !ld_en) |=> cnt_q == $past(cnt_q) - CW'(1));
endmodule

// File: rtl/dbg_ibp.sv
// Instruction comparator: compares the executed address and can be gated by the qualifier.
// Assumes: AW <= DW; local offsets 0 address, 1 control, 2 pass count.
module dbg_ibp #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_off,
    input  logic [DW-1:0] wr_data,
    input  logic          ex_valid,
    input  logic [AW-1:0] ex_addr,
    input  logic          qual_ok,
    output logic          hit
);
    logic [AW-1:0] addr_q;
    logic          en_q;
    logic          qreq_q;
    logic          raw;

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            en_q   <= 1'b0;
            qreq_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_off == 2'd0) addr_q <= wr_data[AW-1:0];
            if (wr_off == 2'd1) begin
                en_q   <= wr_data[0];
                qreq_q <= wr_data[1];
            end
        end
    end

    // Raw match, gated by the qualifier when requested.
    assign raw = en_q && ex_valid && (ex_addr == addr_q) && (!qreq_q || qual_ok);

    dbg_pass_ctr #(.CW(CW)) u_pass (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_en (wr_en && (wr_off == 2'd2)),
        .ld_val(wr_data[CW-1:0]),
        .raw   (raw),
        .fire  (hit)
    );

    p_qual_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && qreq_q) |-> qual_ok);
endmodule

// File: rtl/dbg_dbp.sv
// Data comparator: address, optional direction and byte-masked value compare.
// Assumes: DW is a multiple of 8; offsets 0 address, 1 value, 2 control, 3 pass count.
module dbg_dbp #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_off,
    input  logic [DW-1:0] wr_data,
    input  logic          mem_valid,
    input  logic [AW-1:0] mem_addr,
    input  logic          mem_write,
    input  logic [DW-1:0] mem_data,
    output logic          acc_hit,
    output logic          hit
);
    localparam int NB = DW / 8;

    logic [AW-1:0] addr_q;
    logic [DW-1:0] val_q;
    logic          en_q;
    logic          dchk_q;
    logic          dwr_q;
    logic [NB-1:0] bmask_q;
    logic [DW-1:0] bit_mask;
    logic          raw;

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            val_q   <= '0;
            en_q    <= 1'b0;
            dchk_q  <= 1'b0;
            dwr_q   <= 1'b0;
            bmask_q <= '0;
        end else if (wr_en) begin
            if (wr_off == 2'd0) addr_q <= wr_data[AW-1:0];
            if (wr_off == 2'd1) val_q  <= wr_data;
            if (wr_off == 2'd2) begin
                en_q    <= wr_data[0];
                dchk_q  <= wr_data[1];
                dwr_q   <= wr_data[2];
                bmask_q <= wr_data[4 +: NB];
            end
        end
    end

    // Expand the byte mask to a bit mask.
    for (genvar b = 0; b < NB; b++) begin : g_mask
        assign bit_mask[b*8 +: 8] = {8{bmask_q[b]}};
    end

    // Address and direction hit, then the value compare on top of it.
    assign acc_hit = en_q && mem_valid && (mem_addr == addr_q) && (!dchk_q || (mem_write == dwr_q));
    assign raw     = acc_hit && (((mem_data ^ val_q) & bit_mask) == '0);

    dbg_pass_ctr #(.CW(CW)) u_pass (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_en (wr_en && (wr_off == 2'd3)),
        .ld_val(wr_data[CW-1:0]),
        .raw   (raw),
        .fire  (hit)
    );

    p_hit_needs_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> mem_valid);
endmodule

// File: rtl/dbg_seq.sv
// Primed sequencer: steps through programmed sources in order and fires after the last step.
// Assumes: lengths above NSTEP are clamped; a configuration write restarts at step 0.
module dbg_seq #(
    parameter int NSRC  = 6,
    parameter int NSTEP = 4,
    localparam int SW   = $clog2(NSRC),
    localparam int LW   = $clog2(NSTEP + 1),
    localparam int PW   = (NSTEP > 1) ? $clog2(NSTEP) : 1,
    localparam int CFGW = NSTEP * SW + LW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [CFGW-1:0] cfg_data,
    input  logic [NSRC-1:0] ev,
    output logic            fire
);
    logic [SW-1:0] src_q [NSTEP];
    logic [LW-1:0] len_q;
    logic [PW-1:0] step_q;
    logic [LW-1:0] len_in;
    logic [SW-1:0] cur_src;
    logic          active;
    logic          cur_ev;

    assign len_in  = cfg_data[NSTEP*SW +: LW];
    assign active  = (len_q != '0);
    assign cur_src = src_q[step_q];
    assign cur_ev  = active && (int'(cur_src) < NSRC) && ev[cur_src];
    assign fire    = cur_ev && ((LW'(step_q) + LW'(1)) == len_q);

    // Sequence configuration and step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSTEP; s++) src_q[s] <= '0;
            len_q  <= '0;
            step_q <= '0;
        end else if (cfg_wr) begin
            for (int s = 0; s < NSTEP; s++) src_q[s] <= cfg_data[s*SW +: SW];
            len_q  <= (int'(len_in) > NSTEP) ? LW'(NSTEP) : len_in;
            step_q <= '0;
        end else if (fire) begin
            step_q <= '0;
        end else if (cur_ev) begin
            step_q <= step_q + PW'(1);
        end
    end

    p_step_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (LW'(step_q) < len_q));
    p_idle_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (step_q == '0));
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && !cur_ev) |=> $stable(step_q));
    p_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr || fire) |=> (step_q == '0));
endmodule

// File: rtl/dbg_trig_unit.sv
// Debug trigger unit top: register decode, comparators, sequencer, tuple,
// qualifier and action routing to registered single-cycle trigger pulses.
// Assumes: AW <= DW, N_IBP <= 4, N_DBP <= 4 (two address bits per block).
module dbg_trig_unit
    import dbg_trig_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int CW    = 16,
    parameter int N_IBP = 4,
    parameter int N_DBP = 2,
    parameter int NSTEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [7:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    input  logic          ex_valid,
    input  logic [AW-1:0] ex_addr,
    input  logic          mem_valid,
    input  logic [AW-1:0] mem_addr,
    input  logic          mem_write,
    input  logic [DW-1:0] mem_data,
    output logic          halt_o,
    output logic          trace_on_o,
    output logic          trace_off_o
);
    localparam int NSRC  = N_IBP + N_DBP;
    localparam int NALL  = NSRC + 2;
    localparam int SRC_SEQ = NSRC;
    localparam int SRC_TUP = NSRC + 1;
    localparam int SW    = $clog2(NSRC);
    localparam int LW    = $clog2(NSTEP + 1);
    localparam int SCFGW = NSTEP * SW + LW;
    localparam int ISW   = (N_IBP > 1) ? $clog2(N_IBP) : 1;
    localparam int DSW   = (N_DBP > 1) ? $clog2(N_DBP) : 1;

    logic [N_IBP-1:0] ihit;
    logic [N_DBP-1:0] dhit;
    logic [N_DBP-1:0] dacc;
    logic [NALL-1:0]  ev_all;
    logic             seq_fire;
    logic             tup_fire;
    logic             misc_wr;

    logic             qual_en_q;
    logic [DSW-1:0]   qual_sel_q;
    logic [DW-1:0]    qual_val_q;
    logic             qual_ok_q;

    logic             tup_en_q;
    logic [ISW-1:0]   tup_isel_q;
    logic [DSW-1:0]   tup_dsel_q;
    logic             armed_q;

    logic [2*NALL-1:0] route_q;
    logic             halt_n;
    logic             ton_n;
    logic             toff_n;

    assign misc_wr = cfg_we && (cfg_addr[7:4] == BLK_MISC);

    // Instruction comparators.
    for (genvar i = 0; i < N_IBP; i++) begin : g_ibp
        dbg_ibp #(.AW(AW), .DW(DW), .CW(CW)) u_ibp (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_we && (cfg_addr[7:4] == BLK_IBP) && (int'(cfg_addr[3:2]) == i)),
            .wr_off  (cfg_addr[1:0]),
            .wr_data (cfg_wdata),
            .ex_valid(ex_valid),
            .ex_addr (ex_addr),
            .qual_ok (qual_ok_q),
            .hit     (ihit[i])
        );
    end

    // Data comparators.
    for (genvar j = 0; j < N_DBP; j++) begin : g_dbp
        dbg_dbp #(.AW(AW), .DW(DW), .CW(CW)) u_dbp (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (cfg_we && (cfg_addr[7:4] == BLK_DBP) && (int'(cfg_addr[3:2]) == j)),
            .wr_off   (cfg_addr[1:0]),
            .wr_data  (cfg_wdata),
            .mem_valid(mem_valid),
            .mem_addr (mem_addr),
            .mem_write(mem_write),
            .mem_data (mem_data),
            .acc_hit  (dacc[j]),
            .hit      (dhit[j])
        );
    end

    dbg_seq #(.NSRC(NSRC), .NSTEP(NSTEP)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_wr  (misc_wr && (cfg_addr[3:0] == MISC_SEQ)),
        .cfg_data(cfg_wdata[SCFGW-1:0]),
        .ev      ({dhit, ihit}),
        .fire    (seq_fire)
    );

    // Miscellaneous configuration: tuple, qualifier and routing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tup_en_q   <= 1'b0;
            tup_isel_q <= '0;
            tup_dsel_q <= '0;
            qual_en_q  <= 1'b0;
            qual_sel_q <= '0;
            qual_val_q <= '0;
            route_q    <= '0;
        end else if (misc_wr) begin
            case (cfg_addr[3:0])
                MISC_TUPLE: begin
                    tup_en_q   <= cfg_wdata[0];
                    tup_isel_q <= cfg_wdata[1 +: ISW];
                    tup_dsel_q <= cfg_wdata[3 +: DSW];
                end
                MISC_QCTL: begin
                    qual_en_q  <= cfg_wdata[0];
                    qual_sel_q <= cfg_wdata[1 +: DSW];
                end
                MISC_QVAL:  qual_val_q <= cfg_wdata;
                MISC_ROUTE: route_q    <= cfg_wdata[2*NALL-1:0];
                default: ;
            endcase
        end
    end

    // Qualifier state follows the value seen at the designated data comparator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qual_ok_q <= 1'b0;
        end else if (qual_en_q && dacc[qual_sel_q]) begin
            qual_ok_q <= (mem_data == qual_val_q);
        end
    end

    // Tuple: arm on the instruction hit, decide on the first later data access.
    assign tup_fire = tup_en_q && armed_q && mem_valid && dhit[tup_dsel_q];

    always_ff @(posedge clk) begin
        if (!rst_n || !tup_en_q) begin
            armed_q <= 1'b0;
        end else if (ihit[tup_isel_q]) begin
            armed_q <= 1'b1;
        end else if (mem_valid) begin
            armed_q <= 1'b0;
        end
    end

    assign ev_all = {tup_fire, seq_fire, dhit, ihit};

    // Route each firing source to its action.
    always_comb begin
        halt_n = 1'b0;
        ton_n  = 1'b0;
        toff_n = 1'b0;
        for (int k = 0; k < NALL; k++) begin
            if (ev_all[k]) begin
                case (act_e'(route_q[2*k +: 2]))
                    ACT_HALT:  halt_n = 1'b1;
                    ACT_TRON:  ton_n  = 1'b1;
                    ACT_TROFF: toff_n = 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // Registered trigger outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_o      <= 1'b0;
            trace_on_o  <= 1'b0;
            trace_off_o <= 1'b0;
        end else begin
            halt_o      <= halt_n;
            trace_on_o  <= ton_n;
            trace_off_o <= toff_n;
        end
    end

    p_qual_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_en_q && dacc[qual_sel_q] && (mem_data == qual_val_q)) |=> qual_ok_q);
    p_qual_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_en_q && dacc[qual_sel_q] && (mem_data != qual_val_q)) |=> !qual_ok_q);
    p_tuple_disarm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && mem_valid && !ihit[tup_isel_q]) |=> !armed_q);
    p_seq_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_fire && (route_q[2*SRC_SEQ +: 2] == 2'(ACT_HALT))) |=> halt_o);
    p_tup_tron_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tup_fire && (route_q[2*SRC_TUP +: 2] == 2'(ACT_TRON))) |=> trace_on_o);
endmodule

// File: tb/dbg_trig_unit_test.sv
module dbg_trig_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        ex_valid = 1'b0;
    logic [31:0] ex_addr = '0;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_addr = '0;
    logic        mem_write = 1'b0;
    logic [31:0] mem_data = '0;
    logic        halt_o, trace_on_o, trace_off_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [2:0] got;

    dbg_trig_unit uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ex_valid(ex_valid), .ex_addr(ex_addr),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_write(mem_write),
        .mem_data(mem_data), .halt_o(halt_o), .trace_on_o(trace_on_o),
        .trace_off_o(trace_off_o)
    );

    always #2 clk = ~clk;

    // Compare {halt, trace_on, trace_off} sampled after a cycle.
    task automatic chk(string req, logic [2:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs {halt,on,off} actual %b expected %b", req, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One bus cycle; outputs registered from it are captured at the next negedge.
    task automatic cyc(logic iv, logic [31:0] ia, logic dv, logic [31:0] da,
                       logic dw, logic [31:0] dd);
        ex_valid = iv; ex_addr = ia;
        mem_valid = dv; mem_addr = da; mem_write = dw; mem_data = dd;
        @(negedge clk);
        got = {halt_o, trace_on_o, trace_off_o};
        ex_valid = 1'b0; mem_valid = 1'b0;
    endtask

    task automatic instr(logic [31:0] a);
        cyc(1'b1, a, 1'b0, '0, 1'b0, '0);
    endtask

    task automatic mem(logic [31:0] a, logic w, logic [31:0] d);
        cyc(1'b0, '0, 1'b1, a, w, d);
    endtask

    task automatic t_reset;
        cyc(1'b0, '0, 1'b0, '0, 1'b0, '0);
        chk("R8 reset outputs low", 3'b000);
        instr(32'h0);
        chk("R8 comparators disabled after reset", 3'b000);
    endtask

    task automatic t_ibp;
        wr(8'h00, 32'h100);
        instr(32'h100);
        chk("R7 disabled comparator silent", 3'b000);
        wr(8'h01, 32'h1);
        instr(32'h100);
        chk("R7 address match halts", 3'b100);
        instr(32'h104);
        chk("R5 halt is one cycle only", 3'b000);
    endtask

    task automatic t_pass;
        wr(8'h04, 32'h200);
        wr(8'h05, 32'h1);
        wr(8'h06, 32'd3);
        for (int n = 1; n <= 6; n++) begin
            instr(32'h200);
            chk("R3 every third match", (n % 3 == 0) ? 3'b010 : 3'b000);
        end
    endtask

    task automatic t_dbp;
        wr(8'h10, 32'h4000);
        wr(8'h11, 32'h0000_00AB);
        wr(8'h12, 32'h17);
        mem(32'h4000, 1'b0, 32'hAB);
        chk("R6 direction mismatch ignored", 3'b000);
        mem(32'h4000, 1'b1, 32'h1234_56AB);
        chk("R6 masked value match", 3'b001);
        mem(32'h4000, 1'b1, 32'h0000_00CD);
        chk("R6 masked value mismatch", 3'b000);
        mem(32'h4004, 1'b1, 32'hAB);
        chk("R6 address mismatch", 3'b000);
    endtask

    task automatic t_seq;
        wr(8'h08, 32'h300); wr(8'h09, 32'h1);
        wr(8'h0C, 32'h400); wr(8'h0D, 32'h1);
        wr(8'h14, 32'h5000); wr(8'h16, 32'h1);
        wr(8'h20, 32'd2 | (32'd5 << 3) | (32'd3 << 6) | (32'd3 << 12));
        instr(32'h400);
        chk("R1 last step first does nothing", 3'b000);
        instr(32'h300);
        chk("R1 step 0", 3'b000);
        instr(32'h400);
        chk("R1 out-of-order member ignored", 3'b000);
        mem(32'h5000, 1'b0, 32'h0);
        chk("R1 data breakpoint step", 3'b000);
        instr(32'h400);
        chk("R1 sequence completes", 3'b100);
        instr(32'h400);
        chk("R1 returns to step 0 after firing", 3'b000);
        instr(32'h300);
        mem(32'h5000, 1'b0, 32'h0);
        wr(8'h20, 32'd2 | (32'd5 << 3) | (32'd3 << 6) | (32'd3 << 12));
        instr(32'h400);
        chk("R1 config write restarts sequence", 3'b000);
        instr(32'h300);
        mem(32'h5000, 1'b0, 32'h0);
        instr(32'h400);
        chk("R1 full sequence after restart", 3'b100);
        wr(8'h20, 32'h0);
    endtask

    task automatic t_tuple;
        wr(8'h21, 32'h1 | (32'd2 << 1) | (32'd1 << 3));
        instr(32'h300);
        chk("R2 instruction half alone", 3'b000);
        mem(32'h5000, 1'b0, 32'h0);
        chk("R2 tuple fires", 3'b010);
        instr(32'h300);
        mem(32'h6000, 1'b0, 32'h0);
        chk("R2 mismatching access", 3'b000);
        mem(32'h5000, 1'b0, 32'h0);
        chk("R2 cancelled tuple stays silent", 3'b000);
        instr(32'h300);
        cyc(1'b0, '0, 1'b0, '0, 1'b0, '0);
        mem(32'h5000, 1'b1, 32'h0);
        chk("R2 idle cycle keeps tuple armed", 3'b010);
        wr(8'h21, 32'h0);
    endtask

    task automatic t_qual;
        wr(8'h24, 32'h9049);
        wr(8'h0D, 32'h3);
        wr(8'h22, 32'h1);
        wr(8'h23, 32'd7);
        instr(32'h400);
        chk("R4 qualifier cleared at reset", 3'b000);
        mem(32'h4000, 1'b1, 32'd7);
        chk("R4 qualifying store no trigger", 3'b000);
        instr(32'h400);
        chk("R4 enabled by matching value", 3'b100);
        mem(32'h4000, 1'b1, 32'd8);
        instr(32'h400);
        chk("R4 disabled by other value", 3'b000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        wr(8'h24, 32'h9309);
        t_ibp();
        t_pass();
        t_dbp();
        t_seq();
        t_tuple();
        t_qual();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule